// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter Timer

This block is a 16-bit timer that counts down and raises a level interrupt each time the count runs out. Software programs it through a small register bus with an address, a write strobe, write data and combinational read data. The bus has three registers: control/status, modulus and the current count. An input tick, typically a strobe at half the system clock rate, passes through a power-of-two prescaler. The prescaler output sets the rate at which the count steps down.

When the count runs out, the counter either reloads from the modulus register or wraps to the all-ones value and keeps running freely. Either event sets a sticky interrupt flag. The interrupt output is that flag gated by an interrupt-enable bit. An overwrite option lets a modulus write take effect in the count at once. A control write that touches only the interrupt bits never disturbs the running count.

Top module: `ptmr_timer`

## Requirements
- R1: After reset, control reads 0x0000, modulus reads 0xFFFF, count reads 0xFFFF, and `irq_o` is low.
- R2: Reads return the register at the byte offset on `addr_i`: control at 0, modulus at 2, count at 4. Any other offset reads 0. Read data is combinational.
- R3: Control bit layout: enable bit 0, reload-mode bit 1, flag bit 2, interrupt-enable bit 3, overwrite bit 4, two spare mode bits 5 and 6, and prescale select bits 11:8. The spare mode bits are stored and read back with no effect on counting. Bits 7 and 15:12 read 0.
- R4: `irq_o` is high exactly when the flag (bit 2) and interrupt-enable (bit 3) are both set.
- R5: Writing 1 to control bit 2 clears the flag. Writing 0 there leaves it unchanged. A write never sets it.
- R6: On each prescaled step the count decreases by one. A step taken while the count is 0 is an expiry: it sets the flag and loads the count with the modulus when bit 1 is set, or with 0xFFFF when bit 1 is clear.
- R7: While enable is set, a step occurs on every 2^select-th cycle with `tick_i` high. While enable is clear, the count holds and the prescale phase is cleared.
- R8: A control write that differs from the stored control in any bit other than 2 and 3 clears the prescale phase. If the written enable bit is 1, the write also loads the count, on the next edge, with the reload value selected by the written bit 1. A step in that cycle is discarded.
- R9: A control write that differs from the stored control only in bits 2 and 3 leaves the count and the prescale phase running undisturbed.
- R10: A modulus write clears the flag. With overwrite set, the count takes the written value on the next edge and the prescale phase restarts. Without overwrite, the new value is used at the next expiry.
- R11: Writes to offset 4 are ignored.
- R12: If an expiry coincides with a flag clear, whether by a write-1 or by a modulus write, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-rate strobe ahead of the prescaler |
| addr_i | input | 3 | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
The properties assume that each bus write lasts a single cycle and selects exactly one register. They also assume that `tick_i` and the bus inputs are stable around the clock edge. The hold and read-only checks further assume that no step can slip in while the counter is disabled. The stimulus drives every input only at the falling edge and issues one-cycle writes. In its random phase it keeps the prescale select small and the modulus short, so that expiries, coinciding clears and overwrites occur often rather than never.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_MOD  = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 3'd4;

  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_RLD  = 1;
  localparam int unsigned B_FLAG = 2;
  localparam int unsigned B_IE   = 3;
  localparam int unsigned B_OVW  = 4;
  localparam int unsigned PRE_LSB = 8;

  localparam logic [REG_W-1:0] CTRL_MASK = 16'h0F7F;
  localparam logic [REG_W-1:0] IRQ_BITS  = 16'h000C;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [PRE_W-1:0] sel_i,
  output logic             step_o
);
  localparam int unsigned DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] phase_q, limit;

  // limit = 2^sel - 1 as a thermometer
  always_comb begin
    for (int i = 0; i < DIV_W; i++) limit[i] = (i < int'(sel_i));
  end

  assign step_o = run_i & tick_i & ~clr_i & (phase_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               phase_q <= '0;
    else if (clr_i || !run_i)  phase_q <= '0;
    else if (tick_i)           phase_q <= step_o ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;

  assign count_o  = count_q;
  assign expire_o = step_i & ~load_i & (count_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '1;
    else if (load_i)   count_q <= load_val_i;
    else if (step_i)   count_q <= (count_q == '0) ? reload_val_i : count_q - 1'b1;
  end
endmodule

// File: rtl/ptmr_timer.sv
module ptmr_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic [2:0]  addr_i,
  input  logic        we_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        irq_o
);
  import ptmr_pkg::*;

  logic [REG_W-1:0] ctrl_q, ctrl_d, ctrl_wval;
  logic [CNT_W-1:0] mod_q, cnt_q, load_val, reload_val;
  logic wr_ctrl, wr_mod, irq_only, restart, ovw_load, cnt_load;
  logic step, expire, flag_d;

  assign wr_ctrl   = we_i && (addr_i == OFF_CTRL);
  assign wr_mod    = we_i && (addr_i == OFF_MOD);
  assign ctrl_wval = wdata_i & CTRL_MASK;
  assign irq_only  = ((ctrl_q ^ ctrl_wval) & ~IRQ_BITS) == '0;
  assign restart   = wr_ctrl & ~irq_only;
  assign ovw_load  = wr_mod & ctrl_q[B_OVW];
  assign cnt_load  = (restart & ctrl_wval[B_EN]) | ovw_load;

  assign load_val   = ovw_load ? wdata_i[CNT_W-1:0]
                                : (ctrl_wval[B_RLD] ? mod_q : '1);
  assign reload_val = ctrl_q[B_RLD] ? mod_q : '1;

  ptmr_prescaler #(.PRE_W(PRE_W)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q[B_EN]),
    .clr_i  (restart | ovw_load),
    .tick_i (tick_i),
    .sel_i  (ctrl_q[PRE_LSB +: PRE_W]),
    .step_o (step)
  );

  ptmr_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_i       (step),
    .load_i       (cnt_load),
    .load_val_i   (load_val),
    .reload_val_i (reload_val),
    .count_o      (cnt_q),
    .expire_o     (expire)
  );

  // expiry beats any clear in the same cycle
  assign flag_d = expire | (ctrl_q[B_FLAG] & ~(wr_ctrl & wdata_i[B_FLAG]) & ~wr_mod);

  always_comb begin
    ctrl_d = wr_ctrl ? ctrl_wval : ctrl_q;
    ctrl_d[B_FLAG] = flag_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mod_q  <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_mod) mod_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_CTRL: rdata_o = ctrl_q;
      OFF_MOD:  rdata_o = REG_W'(mod_q);
      OFF_CNT:  rdata_o = REG_W'(cnt_q);
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = ctrl_q[B_IE] & ctrl_q[B_FLAG];
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [2:0]       addr_i,
  input logic             we_i,
  input logic [15:0]      wdata_i,
  input logic             irq_o,
  input logic [15:0]      ctrl_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             expire
);
  assert_irq_needs_ie_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl_q[3]);

  assert_w1c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd0 && wdata_i[2] && !expire) |=> !ctrl_q[2]);

  assert_expiry_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> ctrl_q[2]);

  assert_hold_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[0] && !we_i) |=> $stable(cnt_q));

  assert_irq_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd0 && ((ctrl_q ^ wdata_i) & 16'h0F73) == 16'h0 && !tick_i)
      |=> $stable(cnt_q));

  assert_overwrite_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd2 && ctrl_q[4]) |=> (cnt_q == $past(wdata_i[CNT_W-1:0])));

  assert_count_ro_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd4 && !ctrl_q[0]) |=> $stable(cnt_q));
endmodule

bind ptmr_timer ptmr_checker #(.CNT_W(CNT_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .ctrl_q  (ctrl_q),
  .cnt_q   (cnt_q),
  .expire  (expire)
);

// File: tb/test_ptmr_timer.sv
`timescale 1ns/1ps
module test_ptmr_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b1;
  logic [2:0]  addr_i = 3'd0;
  logic        we_i = 1'b0;
  logic [15:0] wdata_i = 16'h0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int n_run = 0, n_fail = 0;
  int m_ctrl = 0, m_mod = 'hFFFF, m_cnt = 'hFFFF, m_pc = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  ptmr_timer i_ptmr_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_ctrl = 0; m_mod = 'hFFFF; m_cnt = 'hFFFF; m_pc = 0;
    end else begin
      int wd, en, rld, ovw, fl, pre, nf;
      bit wc, wm, ionly, ex;
      wd = int'(wdata_i);
      wc = we_i && addr_i == 0;
      wm = we_i && addr_i == 2;
      en = m_ctrl & 1; rld = (m_ctrl >> 1) & 1; fl = (m_ctrl >> 2) & 1;
      ovw = (m_ctrl >> 4) & 1; pre = (m_ctrl >> 8) & 15;
      ionly = ((m_ctrl ^ wd) & 'h0F73) == 0;
      ex = 0;
      if (wc && !ionly) begin
        m_pc = 0;
        if ((wd & 1) != 0) m_cnt = ((wd & 2) != 0) ? m_mod : 'hFFFF;
      end else if (wm && ovw == 1) begin
        m_pc = 0; m_cnt = wd;
      end else if (en == 0) begin
        m_pc = 0;
      end else if (tick_i) begin
        if (m_pc == (1 << pre) - 1) begin
          m_pc = 0;
          if (m_cnt == 0) begin m_cnt = (rld == 1) ? m_mod : 'hFFFF; ex = 1; end
          else m_cnt = m_cnt - 1;
        end else m_pc = m_pc + 1;
      end
      nf = (ex || (fl == 1 && !(wc && (wd & 4) != 0) && !wm)) ? 1 : 0;
      if (wc) m_ctrl = (wd & 'h0F7B) | (nf << 2);
      else    m_ctrl = (m_ctrl & ~4) | (nf << 2);
      if (wm) m_mod = wd;
    end
  end

  // per-cycle comparison away from the edge
  always @(posedge clk_i) begin
    #3;
    if (rst_ni && !done) begin
      int e;
      e = (addr_i == 0) ? m_ctrl : (addr_i == 2) ? m_mod : (addr_i == 4) ? m_cnt : 0;
      check("R4 model irq", int'(irq_o), ((m_ctrl >> 3) & (m_ctrl >> 2)) & 1);
      check("R2 model rdata", int'(rdata_o), e);
    end
  end

  task automatic wr(int a, int d);
    addr_i = 3'(a); wdata_i = 16'(d); we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = 3'd4;
  endtask

  task automatic rd(int a, int exp, string tag);
    addr_i = 3'(a);
    #1;
    check(tag, int'(rdata_o), exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rd(0, 'h0000, "R1 ctrl reset");
    rd(2, 'hFFFF, "R1 mod reset");
    rd(4, 'hFFFF, "R1 count reset");
    check("R1 irq reset", int'(irq_o), 0);
    rst_ni = 1'b1;
    idle(1);
    rd(6, 0, "R2 unmapped offset");

    wr(2, 5);
    wr(0, 'h000B);
    rd(4, 5, "R8 restart loads modulus");
    idle(6);
    rd(4, 5, "R6 reload after expiry");
    rd(0, 'h000F, "R6 flag set on expiry");
    check("R4 irq high", int'(irq_o), 1);
    wr(0, 'h000B);
    rd(0, 'h000F, "R5 write 0 keeps flag");
    rd(4, 4, "R9 irq-only write keeps counting");
    wr(0, 'h0003);
    check("R4 irq low without enable", int'(irq_o), 0);
    rd(4, 3, "R9 ie change keeps counting");
    wr(0, 'h000F);
    rd(0, 'h000B, "R5 write 1 clears flag");

    wr(0, 'h020F);
    rd(4, 5, "R8 prescale change restarts");
    idle(3);
    rd(4, 5, "R7 divide by four hold");
    idle(1);
    rd(4, 4, "R7 divide by four step");

    wr(0, 'h0019);
    rd(4, 'hFFFF, "R8 free-run loads max");
    wr(2, 0);
    rd(4, 0, "R10 overwrite loads count");
    idle(1);
    rd(4, 'hFFFF, "R6 free-run wraps to max");
    check("R6 irq on wrap", int'(irq_o), 1);

    wr(0, 'h000B);
    rd(4, 0, "R8 restart with zero modulus");
    wr(2, 7);
    rd(4, 0, "R10 no overwrite keeps count");
    rd(0, 'h000F, "R12 expiry beats modulus clear");
    idle(1);
    rd(4, 7, "R10 new modulus at next reload");
    wr(0, 'h000F);
    rd(0, 'h000B, "R5 clear before coincidence");
    idle(6);
    rd(4, 0, "R6 count reaches zero");
    wr(0, 'h000F);
    check("R12 expiry beats write-1 clear", int'(irq_o), 1);
    rd(4, 7, "R6 reload on coincidence");

    wr(4, 'h1234);
    rd(4, 6, "R11 count write ignored");
    rd(2, 7, "R11 modulus untouched");
    wr(0, 'hF064);
    rd(0, 'h0060, "R3 spare bits stored, reserved zero");
    idle(5);
    rd(4, 6, "R7 disabled count holds");
    check("R3 irq low", int'(irq_o), 0);

    for (int i = 0; i < 3000; i++) begin
      tick_i = (i % 500 < 250) ? 1'b1 : 1'($urandom % 2);
      if ($urandom % 6 == 0) begin
        int a, d;
        a = int'(($urandom % 4) * 2);
        if (a == 0) d = int'(($urandom & 'h007F) | (($urandom % 3) << 8) | ((($urandom % 4) != 0) ? 1 : 0));
        else if (a == 2) d = int'($urandom % 12);
        else d = int'($urandom & 'hFFFF);
        wr(a, d);
      end else begin
        addr_i = 3'(($urandom % 4) * 2);
        idle(1);
      end
    end
    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule